// File: doc/BRIEF.md
# Interrupt Presentation Priority Controller

This block sits beside one processor and decides whether an interrupt should be presented to it. It holds four values: the processor's current priority, the priority of an inter-processor interrupt (IPI) request, one pending source number, and the priority of that pending source. Priorities are 8-bit. A numerically lower value is more favoured, and the all-ones value means that nothing is pending. The interrupt line to the processor is a pure function of this state.

The block takes five single-cycle commands:
- deliver an external source;
- accept the pending interrupt;
- set the processor priority;
- set the IPI priority;
- end of interrupt (EOI).

When a pending source loses its slot, the block does not drop it. It hands the source back on a registered reject strobe so that the source controller can deliver it again. When a delivery loses, the block latches a resend flag. That flag is released as a one-cycle resend strobe only when a command lowers the processor's priority or relaxes the IPI priority in a way that lets a deferred source be offered again.

Top module: `irq_presenter`

## Requirements
- R1: After reset the processor priority and the IPI priority are 0xFF, no source is pending (source 0, pending priority 0xFF), the resend flag is clear, and every output is low.
- R2: `irq_out` is high exactly when the pending source number is nonzero and the pending priority is strictly less than the processor priority. It reflects the state in the cycle after the command that changed it.
- R3: At most one command acts per cycle. When several valid inputs are high, the precedence is deliver, then accept, then set-processor-priority, then set-IPI, then EOI. All the lower ones are ignored.
- R4: Delivering a nonzero source whose priority is below both the processor priority and the pending priority replaces the pending source and rejects the old one. Otherwise the delivered source is itself rejected and the resend flag is set. Delivering source 0 does nothing.
- R5: Accept produces `acc_word` = {processor priority in bits 31:24, pending source in bits 23:0}, with `acc_rdy` high in the next cycle. If a source was pending, the processor priority takes the pending priority, the pending priority becomes 0xFF, and the source is cleared. If no source was pending, the state is unchanged.
- R6: Set-IPI always stores the new value. If the new value is below the processor priority, the pending slot becomes IPI source 2 at that priority. The old source is rejected only if the new value is less than or equal to its pending priority; otherwise it is overwritten without a reject.
- R7: Set-IPI with a value greater than both the old IPI priority and the processor priority emits the resend flag on `resend_pulse` and clears the flag.
- R8: Writing a processor priority below the current one raises priority. If the new value is less than or equal to the pending priority, the pending source is rejected, the source is cleared, and the pending priority becomes 0xFF. Writing the current value changes nothing and raises no strobe.
- R9: Writing a processor priority above the current one lowers priority. If the IPI priority is below the new value and less than or equal to the pending priority, IPI source 2 becomes pending at the IPI priority. The resend flag is always emitted on `resend_pulse` and cleared.
- R10: EOI takes a 32-bit word. Bits 31:24 are applied as a priority-lowering write under R9. Bits 23:0 name the finished source. If that source is not 2 and `eoi_level` is high, the source is reported on the reject output.
- R11: The reject and resend strobes are registered and last one cycle. A rejected source of 0 or 2 never raises `rej_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dlv_valid | input | 1 | Deliver-source command |
| dlv_src | input | 24 | Source number being delivered |
| dlv_prio | input | 8 | Priority of the delivered source |
| acc_valid | input | 1 | Accept command |
| cpr_valid | input | 1 | Set-processor-priority command |
| cpr_value | input | 8 | New processor priority |
| ipi_valid | input | 1 | Set-IPI-priority command |
| ipi_value | input | 8 | New IPI priority |
| eoi_valid | input | 1 | End-of-interrupt command |
| eoi_word | input | 32 | Bits 31:24 new priority, bits 23:0 finished source |
| eoi_level | input | 1 | Level input of the finished source is still asserted |
| irq_out | output | 1 | Interrupt line to the processor |
| acc_rdy | output | 1 | Accept word valid (one cycle) |
| acc_word | output | 32 | Processor priority and accepted source |
| rej_valid | output | 1 | Reject strobe (one cycle) |
| rej_src | output | 24 | Rejected source number |
| resend_pulse | output | 1 | Resend request strobe (one cycle) |

## Verification
The hardest case to reach from the ports is a `resend_pulse` that actually carries a set flag. The flag is set only by a delivery that loses. It is released only by a lowering write, an EOI, or an IPI write that exceeds both the old IPI priority and the processor priority.

The stimulus therefore first raises the processor priority by accepting a favoured source, then sends a losing delivery to set the flag. It then releases the flag once through a lowering write and once through an IPI relaxation. A second hard case is an IPI write whose priority lies between the pending priority and the processor priority, which silently overwrites an external source. The stimulus sets up an external source at priority 2 under processor priority 8 and then writes IPI priority 4.

// File: rtl/irqp_pkg.sv
package irqp_pkg;
  typedef enum logic [2:0] {
    CMD_NONE = 3'd0,
    CMD_DLV  = 3'd1,
    CMD_ACC  = 3'd2,
    CMD_CPR  = 3'd3,
    CMD_IPI  = 3'd4,
    CMD_EOI  = 3'd5
  } irqp_cmd_e;
endpackage

// File: rtl/irqp_cmd_sel.sv
module irqp_cmd_sel
  import irqp_pkg::*;
(
  input  logic      dlv_valid,
  input  logic      acc_valid,
  input  logic      cpr_valid,
  input  logic      ipi_valid,
  input  logic      eoi_valid,
  output irqp_cmd_e cmd
);
  // Fixed precedence: deliver > accept > processor priority > IPI > EOI
  always_comb begin
    if (dlv_valid)      cmd = CMD_DLV;
    else if (acc_valid) cmd = CMD_ACC;
    else if (cpr_valid) cmd = CMD_CPR;
    else if (ipi_valid) cmd = CMD_IPI;
    else if (eoi_valid) cmd = CMD_EOI;
    else                cmd = CMD_NONE;
  end
endmodule

// File: rtl/irqp_update.sv
module irqp_update
  import irqp_pkg::*;
#(
  parameter int PRIO_W  = 8,
  parameter int SRC_W   = 24,
  parameter int IPI_SRC = 2
) (
  input  irqp_cmd_e                  cmd,
  input  logic [SRC_W-1:0]           dlv_src,
  input  logic [PRIO_W-1:0]          dlv_prio,
  input  logic [PRIO_W-1:0]          cpr_value,
  input  logic [PRIO_W-1:0]          ipi_value,
  input  logic [PRIO_W+SRC_W-1:0]    eoi_word,
  input  logic                       eoi_level,
  input  logic [PRIO_W-1:0]          cpr_q,
  input  logic [PRIO_W-1:0]          ipi_q,
  input  logic [SRC_W-1:0]           src_q,
  input  logic [PRIO_W-1:0]          pend_q,
  input  logic                       flag_q,
  output logic [PRIO_W-1:0]          cpr_d,
  output logic [PRIO_W-1:0]          ipi_d,
  output logic [SRC_W-1:0]           src_d,
  output logic [PRIO_W-1:0]          pend_d,
  output logic                       flag_d,
  output logic                       rej_fire,
  output logic [SRC_W-1:0]           rej_cand,
  output logic                       resend_fire,
  output logic                       acc_fire,
  output logic [PRIO_W+SRC_W-1:0]    acc_word_d
);
  localparam logic [PRIO_W-1:0] PRIO_IDLE = {PRIO_W{1'b1}};
  localparam logic [SRC_W-1:0]  SRC_IPI   = SRC_W'(IPI_SRC);

  logic [PRIO_W-1:0] eoi_prio;
  logic [SRC_W-1:0]  eoi_src;
  logic [PRIO_W-1:0] low_v;
  logic              low_ipi_wins;

  assign eoi_prio = eoi_word[PRIO_W+SRC_W-1:SRC_W];
  assign eoi_src  = eoi_word[SRC_W-1:0];

  // Shared priority-lowering path (set-priority upward and EOI)
  assign low_v        = (cmd == CMD_EOI) ? eoi_prio : cpr_value;
  assign low_ipi_wins = (ipi_q < low_v) && (ipi_q <= pend_q);

  always_comb begin
    cpr_d       = cpr_q;
    ipi_d       = ipi_q;
    src_d       = src_q;
    pend_d      = pend_q;
    flag_d      = flag_q;
    rej_cand    = '0;
    resend_fire = 1'b0;
    acc_fire    = 1'b0;
    acc_word_d  = {cpr_q, src_q};
    unique case (cmd)
      CMD_DLV: begin
        if (dlv_src != '0) begin
          if ((dlv_prio < cpr_q) && (dlv_prio < pend_q)) begin
            rej_cand = src_q;
            src_d    = dlv_src;
            pend_d   = dlv_prio;
          end else begin
            rej_cand = dlv_src;
            flag_d   = 1'b1;
          end
        end
      end
      CMD_ACC: begin
        acc_fire = 1'b1;
        if (src_q != '0) begin
          cpr_d  = pend_q;
          pend_d = PRIO_IDLE;
          src_d  = '0;
        end
      end
      CMD_CPR: begin
        if (cpr_value < cpr_q) begin
          cpr_d = cpr_value;
          if (cpr_value <= pend_q) begin
            rej_cand = src_q;
            src_d    = '0;
            pend_d   = PRIO_IDLE;
          end
        end else if (cpr_value > cpr_q) begin
          cpr_d = low_v;
          if (low_ipi_wins) begin
            pend_d = ipi_q;
            src_d  = SRC_IPI;
          end
          resend_fire = flag_q;
          flag_d      = 1'b0;
        end
      end
      CMD_IPI: begin
        ipi_d = ipi_value;
        if (ipi_value < cpr_q) begin
          if (ipi_value <= pend_q) rej_cand = src_q;
          pend_d = ipi_value;
          src_d  = SRC_IPI;
        end
        if ((ipi_value > ipi_q) && (ipi_value > cpr_q)) begin
          resend_fire = flag_q;
          flag_d      = 1'b0;
        end
      end
      CMD_EOI: begin
        cpr_d = low_v;
        if (low_ipi_wins) begin
          pend_d = ipi_q;
          src_d  = SRC_IPI;
        end
        resend_fire = flag_q;
        flag_d      = 1'b0;
        if ((eoi_src != SRC_IPI) && eoi_level) rej_cand = eoi_src;
      end
      default: ;
    endcase
  end

  // Sources 0 and the IPI number are never handed back
  assign rej_fire = (rej_cand != '0) && (rej_cand != SRC_IPI);
endmodule

// File: rtl/irqp_strobe_reg.sv
module irqp_strobe_reg #(
  parameter int SRC_W  = 24,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rej_fire,
  input  logic [SRC_W-1:0]  rej_cand,
  input  logic              resend_fire,
  input  logic              acc_fire,
  input  logic [WORD_W-1:0] acc_word_d,
  output logic              rej_valid,
  output logic [SRC_W-1:0]  rej_src,
  output logic              resend_pulse,
  output logic              acc_rdy,
  output logic [WORD_W-1:0] acc_word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rej_valid    <= 1'b0;
      resend_pulse <= 1'b0;
      acc_rdy      <= 1'b0;
    end else begin
      rej_valid    <= rej_fire;
      resend_pulse <= resend_fire;
      acc_rdy      <= acc_fire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rej_src <= '0;
    end else if (rej_fire) begin
      rej_src <= rej_cand;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_word <= '0;
    end else if (acc_fire) begin
      acc_word <= acc_word_d;
    end
  end
endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
  import irqp_pkg::*;
#(
  parameter int PRIO_W  = 8,
  parameter int SRC_W   = 24,
  parameter int IPI_SRC = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    dlv_valid,
  input  logic [SRC_W-1:0]        dlv_src,
  input  logic [PRIO_W-1:0]       dlv_prio,
  input  logic                    acc_valid,
  input  logic                    cpr_valid,
  input  logic [PRIO_W-1:0]       cpr_value,
  input  logic                    ipi_valid,
  input  logic [PRIO_W-1:0]       ipi_value,
  input  logic                    eoi_valid,
  input  logic [PRIO_W+SRC_W-1:0] eoi_word,
  input  logic                    eoi_level,
  output logic                    irq_out,
  output logic                    acc_rdy,
  output logic [PRIO_W+SRC_W-1:0] acc_word,
  output logic                    rej_valid,
  output logic [SRC_W-1:0]        rej_src,
  output logic                    resend_pulse
);
  localparam int                WORD_W    = PRIO_W + SRC_W;
  localparam logic [PRIO_W-1:0] PRIO_IDLE = {PRIO_W{1'b1}};

  irqp_cmd_e         cmd;
  logic [PRIO_W-1:0] cpr_q, ipi_q, pend_q;
  logic [SRC_W-1:0]  src_q;
  logic              flag_q;
  logic [PRIO_W-1:0] cpr_d, ipi_d, pend_d;
  logic [SRC_W-1:0]  src_d;
  logic              flag_d;
  logic              state_en;
  logic              rej_fire, resend_fire, acc_fire;
  logic [SRC_W-1:0]  rej_cand;
  logic [WORD_W-1:0] acc_word_d;

  irqp_cmd_sel u_sel (
    .dlv_valid (dlv_valid),
    .acc_valid (acc_valid),
    .cpr_valid (cpr_valid),
    .ipi_valid (ipi_valid),
    .eoi_valid (eoi_valid),
    .cmd       (cmd)
  );

  irqp_update #(.PRIO_W(PRIO_W), .SRC_W(SRC_W), .IPI_SRC(IPI_SRC)) u_upd (
    .cmd         (cmd),
    .dlv_src     (dlv_src),
    .dlv_prio    (dlv_prio),
    .cpr_value   (cpr_value),
    .ipi_value   (ipi_value),
    .eoi_word    (eoi_word),
    .eoi_level   (eoi_level),
    .cpr_q       (cpr_q),
    .ipi_q       (ipi_q),
    .src_q       (src_q),
    .pend_q      (pend_q),
    .flag_q      (flag_q),
    .cpr_d       (cpr_d),
    .ipi_d       (ipi_d),
    .src_d       (src_d),
    .pend_d      (pend_d),
    .flag_d      (flag_d),
    .rej_fire    (rej_fire),
    .rej_cand    (rej_cand),
    .resend_fire (resend_fire),
    .acc_fire    (acc_fire),
    .acc_word_d  (acc_word_d)
  );

  assign state_en = (cmd != CMD_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpr_q  <= PRIO_IDLE;
      ipi_q  <= PRIO_IDLE;
      src_q  <= '0;
      pend_q <= PRIO_IDLE;
      flag_q <= 1'b0;
    end else if (state_en) begin
      cpr_q  <= cpr_d;
      ipi_q  <= ipi_d;
      src_q  <= src_d;
      pend_q <= pend_d;
      flag_q <= flag_d;
    end
  end

  assign irq_out = (src_q != '0) && (pend_q < cpr_q);

  irqp_strobe_reg #(.SRC_W(SRC_W), .WORD_W(WORD_W)) u_strb (
    .clk          (clk),
    .rst_n        (rst_n),
    .rej_fire     (rej_fire),
    .rej_cand     (rej_cand),
    .resend_fire  (resend_fire),
    .acc_fire     (acc_fire),
    .acc_word_d   (acc_word_d),
    .rej_valid    (rej_valid),
    .rej_src      (rej_src),
    .resend_pulse (resend_pulse),
    .acc_rdy      (acc_rdy),
    .acc_word     (acc_word)
  );
endmodule

// File: rtl/irqp_checker.sv
module irqp_checker #(
  parameter int PRIO_W  = 8,
  parameter int SRC_W   = 24,
  parameter int IPI_SRC = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    dlv_valid,
  input logic                    acc_valid,
  input logic                    cpr_valid,
  input logic [PRIO_W-1:0]       cpr_value,
  input logic                    ipi_valid,
  input logic [PRIO_W-1:0]       ipi_value,
  input logic                    eoi_valid,
  input logic [PRIO_W-1:0]       cpr_q,
  input logic [PRIO_W-1:0]       ipi_q,
  input logic [SRC_W-1:0]        src_q,
  input logic [PRIO_W-1:0]       pend_q,
  input logic                    irq_out,
  input logic                    acc_rdy,
  input logic [PRIO_W+SRC_W-1:0] acc_word,
  input logic                    rej_valid,
  input logic [SRC_W-1:0]        rej_src,
  input logic                    resend_pulse
);
  logic acc_sel, cpr_sel, ipi_sel;
  assign acc_sel = acc_valid && !dlv_valid;
  assign cpr_sel = cpr_valid && !dlv_valid && !acc_valid;
  assign ipi_sel = ipi_valid && !dlv_valid && !acc_valid && !cpr_valid;

  assert_rej_filter_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rej_valid |-> (rej_src != '0) && (rej_src != SRC_W'(IPI_SRC)));

  assert_irq_rise_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> $past(dlv_valid || cpr_valid || ipi_valid || eoi_valid));

  assert_deliver_blocks_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |=> !acc_rdy);

  assert_accept_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_sel |=> acc_rdy && (acc_word == {$past(cpr_q), $past(src_q)}));

  assert_ipi_stored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ipi_sel |=> (ipi_q == $past(ipi_value)));

  assert_equal_cpr_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cpr_sel && (cpr_value == cpr_q)) |=>
      ($stable(cpr_q) && $stable(src_q) && $stable(pend_q) && !rej_valid && !resend_pulse));
endmodule

bind irq_presenter irqp_checker #(.PRIO_W(PRIO_W), .SRC_W(SRC_W), .IPI_SRC(IPI_SRC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dlv_valid    (dlv_valid),
  .acc_valid    (acc_valid),
  .cpr_valid    (cpr_valid),
  .cpr_value    (cpr_value),
  .ipi_valid    (ipi_valid),
  .ipi_value    (ipi_value),
  .eoi_valid    (eoi_valid),
  .cpr_q        (cpr_q),
  .ipi_q        (ipi_q),
  .src_q        (src_q),
  .pend_q       (pend_q),
  .irq_out      (irq_out),
  .acc_rdy      (acc_rdy),
  .acc_word     (acc_word),
  .rej_valid    (rej_valid),
  .rej_src      (rej_src),
  .resend_pulse (resend_pulse)
);

// File: tb/irq_presenter_tb.sv
`timescale 1ns/1ps
module irq_presenter_tb;
  logic        clk;
  logic        rst_n;
  logic        dlv_valid;
  logic [23:0] dlv_src;
  logic [7:0]  dlv_prio;
  logic        acc_valid;
  logic        cpr_valid;
  logic [7:0]  cpr_value;
  logic        ipi_valid;
  logic [7:0]  ipi_value;
  logic        eoi_valid;
  logic [31:0] eoi_word;
  logic        eoi_level;
  logic        irq_out;
  logic        acc_rdy;
  logic [31:0] acc_word;
  logic        rej_valid;
  logic [23:0] rej_src;
  logic        resend_pulse;

  irq_presenter u_dut (
    .clk(clk), .rst_n(rst_n),
    .dlv_valid(dlv_valid), .dlv_src(dlv_src), .dlv_prio(dlv_prio),
    .acc_valid(acc_valid),
    .cpr_valid(cpr_valid), .cpr_value(cpr_value),
    .ipi_valid(ipi_valid), .ipi_value(ipi_value),
    .eoi_valid(eoi_valid), .eoi_word(eoi_word), .eoi_level(eoi_level),
    .irq_out(irq_out), .acc_rdy(acc_rdy), .acc_word(acc_word),
    .rej_valid(rej_valid), .rej_src(rej_src), .resend_pulse(resend_pulse)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct {
    string       tag;
    logic        rej;
    logic [23:0] rsrc;
    logic        rs;
    logic        acc;
    logic [31:0] aword;
    logic        irq;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Reference model of the presenter state
  logic [7:0]  m_cpr, m_ipi, m_pend;
  logic [23:0] m_src;
  logic        m_flag;

  // Monitor: pops one expectation per command and compares
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (rej_valid !== e.rej || (e.rej && rej_src !== e.rsrc) ||
          resend_pulse !== e.rs || acc_rdy !== e.acc ||
          (e.acc && acc_word !== e.aword) || irq_out !== e.irq) begin
        errors++;
        $display("FAIL %s: got rej=%0b src=%h rs=%0b acc=%0b word=%h irq=%0b exp rej=%0b src=%h rs=%0b acc=%0b word=%h irq=%0b",
                 e.tag, rej_valid, rej_src, resend_pulse, acc_rdy, acc_word, irq_out,
                 e.rej, e.rsrc, e.rs, e.acc, e.aword, e.irq);
      end
    end
  end

  task automatic clear_inputs();
    dlv_valid = 0; dlv_src = '0; dlv_prio = '0; acc_valid = 0;
    cpr_valid = 0; cpr_value = '0; ipi_valid = 0; ipi_value = '0;
    eoi_valid = 0; eoi_word = '0; eoi_level = 0;
  endtask

  task automatic finish_cmd(input exp_t e);
    @(posedge clk);
    #1;
    clear_inputs();
    e.irq = (m_src != 0) && (m_pend < m_cpr);
    q.push_back(e);
  endtask

  function automatic exp_t mk(input string tag);
    exp_t e;
    e.tag = tag; e.rej = 0; e.rsrc = '0; e.rs = 0; e.acc = 0; e.aword = '0; e.irq = 0;
    return e;
  endfunction

  function automatic void note_rej(ref exp_t e, input logic [23:0] s);
    if (s != 0 && s != 24'd2) begin e.rej = 1; e.rsrc = s; end
  endfunction

  // Priority-lowering write shared by set-priority and EOI (R9)
  function automatic void model_lower(ref exp_t e, input logic [7:0] v);
    logic [7:0] p;
    p = m_pend;
    m_cpr = v;
    if (m_ipi < v && m_ipi <= p) begin m_pend = m_ipi; m_src = 24'd2; end
    e.rs = m_flag;
    m_flag = 0;
  endfunction

  task automatic do_dlv(input logic [23:0] s, input logic [7:0] p, input bit with_acc, input string tag);
    exp_t e;
    @(negedge clk);
    dlv_valid = 1; dlv_src = s; dlv_prio = p; acc_valid = with_acc;
    e = mk(tag);
    if (s != 0) begin
      if (p < m_cpr && p < m_pend) begin
        note_rej(e, m_src); m_src = s; m_pend = p;
      end else begin
        note_rej(e, s); m_flag = 1;
      end
    end
    finish_cmd(e);
  endtask

  task automatic do_acc(input string tag);
    exp_t e;
    @(negedge clk);
    acc_valid = 1;
    e = mk(tag);
    e.acc = 1; e.aword = {m_cpr, m_src};
    if (m_src != 0) begin m_cpr = m_pend; m_pend = 8'hFF; m_src = 0; end
    finish_cmd(e);
  endtask

  task automatic do_cpr(input logic [7:0] v, input string tag);
    exp_t e;
    @(negedge clk);
    cpr_valid = 1; cpr_value = v;
    e = mk(tag);
    if (v < m_cpr) begin
      m_cpr = v;
      if (v <= m_pend) begin note_rej(e, m_src); m_src = 0; m_pend = 8'hFF; end
    end else if (v > m_cpr) begin
      model_lower(e, v);
    end
    finish_cmd(e);
  endtask

  task automatic do_ipi(input logic [7:0] v, input string tag);
    exp_t e;
    logic [7:0] old;
    @(negedge clk);
    ipi_valid = 1; ipi_value = v;
    e = mk(tag);
    old = m_ipi;
    m_ipi = v;
    if (v > old && v > m_cpr) begin e.rs = m_flag; m_flag = 0; end
    if (v < m_cpr) begin
      if (v <= m_pend) note_rej(e, m_src);
      m_pend = v; m_src = 24'd2;
    end
    finish_cmd(e);
  endtask

  task automatic do_eoi(input logic [31:0] w, input logic lvl, input string tag);
    exp_t e;
    @(negedge clk);
    eoi_valid = 1; eoi_word = w; eoi_level = lvl;
    e = mk(tag);
    model_lower(e, w[31:24]);
    if (w[23:0] != 24'd2 && lvl) note_rej(e, w[23:0]);
    finish_cmd(e);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung run exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clear_inputs();
    m_cpr = 8'hFF; m_ipi = 8'hFF; m_pend = 8'hFF; m_src = 0; m_flag = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    checks++;
    if (irq_out !== 0 || rej_valid !== 0 || resend_pulse !== 0 || acc_rdy !== 0) begin
      errors++;
      $display("FAIL R1: got irq=%0b rej=%0b rs=%0b acc=%0b exp all 0",
               irq_out, rej_valid, resend_pulse, acc_rdy);
    end
    do_dlv(24'h100, 8'd5, 0, "R4 first source wins, R2 irq high");
    do_dlv(24'h200, 8'd3, 0, "R4 better source replaces and rejects old");
    do_dlv(24'h300, 8'd7, 0, "R4 losing source rejected, flag set");
    do_dlv(24'h000, 8'd0, 0, "R4 source zero ignored");
    do_acc("R5 accept pending source");
    do_acc("R5 accept with nothing pending");
    do_cpr(8'd3, "R8 equal priority write does nothing");
    do_ipi(8'd1, "R6 IPI becomes pending");
    do_cpr(8'd1, "R8 raise drops IPI silently R11");
    do_cpr(8'd6, "R9 lower: IPI pending, resend released");
    do_acc("R5 accept IPI");
    do_dlv(24'h400, 8'd0, 0, "R4 favoured source");
    do_dlv(24'h500, 8'd4, 0, "R4 loser sets flag");
    do_ipi(8'h10, "R7 IPI relax releases resend");
    do_acc("R5 accept external");
    do_eoi({8'h20, 24'h400}, 1'b1, "R10 EOI level still high rejects");
    do_eoi({8'h30, 24'h002}, 1'b1, "R10 EOI of IPI no action");
    do_eoi({8'h30, 24'h600}, 1'b0, "R10 EOI level low no reject");
    do_dlv(24'h700, 8'h05, 0, "R11 displaced IPI not reported");
    do_ipi(8'h05, "R6 IPI equal priority rejects external");
    do_cpr(8'h08, "R8 raise above pending keeps source");
    do_dlv(24'h800, 8'h02, 1, "R3 deliver wins over accept");
    do_ipi(8'h04, "R6 IPI overwrite without reject");
    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule